// File: doc/BRIEF.md
# Vector Carryless Multiplier

This block multiplies 64-bit elements as polynomials over GF(2), where partial products are merged with XOR and no carries propagate, and produces a 128-bit product for each 128-bit segment of a vector. A vector holds `MAX_BYTES` bytes, and each 128-bit segment holds two 64-bit elements. One half-select value, captured when the operation starts, picks the even or odd element of every segment from both sources. The full product is written back into the same segment of the destination: the low half goes to the even element and the high half to the odd element.

The active size is given in whole 16-byte segments. Segments inside the active size get products. Every segment from the active size up to the full vector width is cleared to zero.

The destination is held inside the block and driven on `dst_o`. It may be wired back to either source. Each segment's operands are latched one cycle before that segment's product is written, so an aliased source always supplies the contents from before the operation. Work proceeds one segment per cycle after a start pulse. A one-cycle done pulse ends the operation.

Top module: `cvm_pmull_vec`

## Requirements
- R1: For each active segment k (bits 128k+127:128k of `dst_o`), the segment holds the carryless product of source elements a and b. The low 64 product bits land in element 2k and the high 64 in element 2k+1, where element e is bits 64e+63:64e of a vector.
- R2: With `hi_sel_i`=0 the operands of segment k are element 2k of each source. With 1 they are element 2k+1. The value is sampled with the accepted start and applies to every segment.
- R3: `op_segs_i` gives the active size in 16-byte segments. Every segment with index at or above the size reads as zero after done. A size above the vector capacity acts as the full capacity, and a size of 0 clears the whole vector.
- R4: Partial products combine by XOR. Operand a = 1 yields {64'h0, b}. All-ones times all-ones yields 128'h5555...5555. Product bit 127 is always 0.
- R5: A start accepted while idle makes `busy_o` high from the next cycle. `done_o` then pulses high for exactly one cycle, N+1 clock edges after the accepted start edge (N = clamped size). `busy_o` is low while `done_o` is high.
- R6: `start_i`, `hi_sel_i` and `op_segs_i` are ignored while busy. A running operation keeps its original size, half-select and latency.
- R7: When `dst_o` is fed back as `src_a_i`, each segment's product uses the destination contents from before the operation.
- R8: After reset `busy_o` and `done_o` are low and `dst_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| hi_sel_i | input | 1 | Element select: 0 even, 1 odd |
| op_segs_i | input | $clog2(MAX_BYTES/16+1) | Active size in 16-byte segments |
| src_a_i | input | MAX_BYTES*8 | First source vector |
| src_b_i | input | MAX_BYTES*8 | Second source vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | MAX_BYTES*8 | Destination vector |

## Verification
Walking single-bit operands, with a different bit position in every element, show that each shift amount lands in the correct half. They also expose any mix-up of even/odd elements or segments. Random operands swept over every size from 0 to beyond capacity, with both half-select values, separate the product path from the tail clear and the clamp. All-ones and unit operands give known XOR-only results that an adding multiplier or a lost bit-0 term would miss. Further runs poke start and half-select mid-operation and feed the destination back as a source, which shows whether configuration is held and operands are latched before writeback.

// File: rtl/cvm_pkg.sv
package cvm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cvm_state_e;
endpackage

// File: rtl/cvm_clmul.sv
module cvm_clmul #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] pp [W];

  // one shifted copy of b per bit of a
  for (genvar j = 0; j < W; j++) begin : g_pp
    assign pp[j] = a_i[j] ? ({{W{1'b0}}, b_i} << j) : '0;
  end

  always_comb begin
    prod_o = '0;
    for (int j = 0; j < W; j++) prod_o = prod_o ^ pp[j];
  end
endmodule

// File: rtl/cvm_opsel.sv
module cvm_opsel #(
  parameter int ELEM_W = 64,
  parameter int N_ELEM = 32,
  localparam int EIDX_W = $clog2(N_ELEM)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [EIDX_W-1:0]        elem_idx_i,
  input  logic [N_ELEM*ELEM_W-1:0] src_a_i,
  input  logic [N_ELEM*ELEM_W-1:0] src_b_i,
  output logic [ELEM_W-1:0]        op_a_o,
  output logic [ELEM_W-1:0]        op_b_o
);
  logic [ELEM_W-1:0] a_el [N_ELEM];
  logic [ELEM_W-1:0] b_el [N_ELEM];

  for (genvar e = 0; e < N_ELEM; e++) begin : g_unpack
    assign a_el[e] = src_a_i[e*ELEM_W +: ELEM_W];
    assign b_el[e] = src_b_i[e*ELEM_W +: ELEM_W];
  end

  // capture before writeback so an aliased destination reads old data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_o <= '0;
      op_b_o <= '0;
    end else if (load_i) begin
      op_a_o <= a_el[elem_idx_i];
      op_b_o <= b_el[elem_idx_i];
    end
  end
endmodule

// File: rtl/cvm_ctrl.sv
module cvm_ctrl
  import cvm_pkg::*;
#(
  parameter int MAX_SEGS = 16,
  localparam int CNT_W = $clog2(MAX_SEGS + 1),
  localparam int IDX_W = $clog2(MAX_SEGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hi_sel_i,
  input  logic [CNT_W-1:0] op_segs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fetch_o,
  output logic [IDX_W-1:0] fetch_idx_o,
  output logic             hi_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] segs_o
);
  cvm_state_e       state_q;
  logic [CNT_W-1:0] rd_idx_q;
  logic [CNT_W-1:0] segs_q;
  logic [CNT_W-1:0] segs_clamp;
  logic [IDX_W-1:0] pend_idx_q;
  logic             pend_v_q;
  logic             hi_q;
  logic             done_q;
  logic             last;

  assign segs_clamp = (op_segs_i > CNT_W'(MAX_SEGS)) ? CNT_W'(MAX_SEGS) : op_segs_i;
  assign last       = (rd_idx_q == segs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rd_idx_q   <= '0;
      segs_q     <= '0;
      pend_idx_q <= '0;
      pend_v_q   <= 1'b0;
      hi_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_RUN;
            rd_idx_q <= '0;
            pend_v_q <= 1'b0;
            segs_q   <= segs_clamp;
            hi_q     <= hi_sel_i;
          end
        end
        ST_RUN: begin
          if (last) begin
            // final write and tail clear share this edge
            state_q  <= ST_IDLE;
            pend_v_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            pend_v_q   <= 1'b1;
            pend_idx_q <= rd_idx_q[IDX_W-1:0];
            rd_idx_q   <= rd_idx_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_RUN);
  assign done_o      = done_q;
  assign fetch_o     = busy_o && !last;
  assign fetch_idx_o = rd_idx_q[IDX_W-1:0];
  assign hi_o        = hi_q;
  assign wr_o        = pend_v_q;
  assign wr_idx_o    = pend_idx_q;
  assign clr_o       = busy_o && last;
  assign segs_o      = segs_q;

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r3_rd_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rd_idx_q <= segs_q);
  a_r6_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(segs_q) && $stable(hi_q))));
  a_r5_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> busy_o);
endmodule

// File: rtl/cvm_pmull_vec.sv
module cvm_pmull_vec #(
  parameter int ELEM_W    = 64,
  parameter int MAX_BYTES = 256
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       start_i,
  input  logic                                       hi_sel_i,
  input  logic [$clog2(MAX_BYTES*8/(2*ELEM_W)+1)-1:0] op_segs_i,
  input  logic [MAX_BYTES*8-1:0]                     src_a_i,
  input  logic [MAX_BYTES*8-1:0]                     src_b_i,
  output logic                                       busy_o,
  output logic                                       done_o,
  output logic [MAX_BYTES*8-1:0]                     dst_o
);
  localparam int SEG_BITS = 2 * ELEM_W;
  localparam int VEC_W    = MAX_BYTES * 8;
  localparam int MAX_SEGS = VEC_W / SEG_BITS;
  localparam int N_ELEM   = 2 * MAX_SEGS;
  localparam int CNT_W    = $clog2(MAX_SEGS + 1);
  localparam int IDX_W    = $clog2(MAX_SEGS);

  logic                fetch, wr, clr, hi;
  logic [IDX_W-1:0]    fetch_idx, wr_idx;
  logic [CNT_W-1:0]    segs;
  logic [ELEM_W-1:0]   op_a, op_b;
  logic [SEG_BITS-1:0] prod;
  logic [SEG_BITS-1:0] dst_q [MAX_SEGS];

  cvm_ctrl #(.MAX_SEGS(MAX_SEGS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .hi_sel_i    (hi_sel_i),
    .op_segs_i   (op_segs_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fetch_o     (fetch),
    .fetch_idx_o (fetch_idx),
    .hi_o        (hi),
    .wr_o        (wr),
    .wr_idx_o    (wr_idx),
    .clr_o       (clr),
    .segs_o      (segs)
  );

  cvm_opsel #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) i_opsel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fetch),
    .elem_idx_i ({fetch_idx, hi}),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .op_a_o     (op_a),
    .op_b_o     (op_b)
  );

  cvm_clmul #(.W(ELEM_W)) i_clmul (
    .a_i    (op_a),
    .b_i    (op_b),
    .prod_o (prod)
  );

  for (genvar k = 0; k < MAX_SEGS; k++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 dst_q[k] <= '0;
      else if (wr && (wr_idx == IDX_W'(k)))         dst_q[k] <= prod;
      else if (clr && (CNT_W'(k) >= segs))         dst_q[k] <= '0;
    end
    assign dst_o[k*SEG_BITS +: SEG_BITS] = dst_q[k];

    a_r3_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (CNT_W'(k) >= segs)) |-> (dst_q[k] == '0));
  end

  a_r1_wr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> (CNT_W'(wr_idx) < segs));
  a_r4_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> !prod[SEG_BITS-1]);
  a_r4_unit_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (op_a == ELEM_W'(1))) |-> (prod == {{ELEM_W{1'b0}}, op_b}));
endmodule

// File: tb/test_cvm_pmull_vec.sv
`timescale 1ns/1ps
module test_cvm_pmull_vec;
  localparam int MAXB  = 64;
  localparam int VEC_W = MAXB * 8;
  localparam int NSEG  = VEC_W / 128;
  localparam int NEL   = 2 * NSEG;
  localparam int CNT_W = $clog2(NSEG + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic hi_sel = 1'b0;
  logic alias_en = 1'b0;
  logic [CNT_W-1:0] op_segs = '0;
  logic [63:0] a_el [NEL];
  logic [63:0] b_el [NEL];
  logic [VEC_W-1:0] a_vec, b_vec, src_a, dst;
  logic busy, done;
  logic [127:0] exp_seg [NSEG];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int e = 0; e < NEL; e++) begin
      a_vec[e*64 +: 64] = a_el[e];
      b_vec[e*64 +: 64] = b_el[e];
    end
  end
  assign src_a = alias_en ? dst : a_vec;

  cvm_pmull_vec #(.ELEM_W(64), .MAX_BYTES(MAXB)) i_cvm_pmull_vec (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .hi_sel_i(hi_sel),
    .op_segs_i(op_segs), .src_a_i(src_a), .src_b_i(b_vec),
    .busy_o(busy), .done_o(done), .dst_o(dst)
  );

  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] r = '0;
    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 64; j++)
        if (i - j >= 0 && i - j < 64) r[i] = r[i] ^ (x[j] & y[i-j]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(input int segs, input bit hi, input bit al, input bit poke, input string tag);
    int nc, cnt;
    logic [63:0] ea;
    logic [127:0] nxt [NSEG];
    nc = (segs > NSEG) ? NSEG : segs;
    for (int k = 0; k < NSEG; k++) begin
      if (k < nc) begin
        ea = al ? (hi ? exp_seg[k][127:64] : exp_seg[k][63:0]) : a_el[2*k+hi];
        nxt[k] = ref_mul(ea, b_el[2*k+hi]);
      end else nxt[k] = '0;
    end
    @(negedge clk);
    alias_en = al; op_segs = CNT_W'(segs); hi_sel = hi; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy after start", {127'd0, busy}, 128'd1);
    cnt = 0;
    while (!done && cnt < 64) begin
      if (poke && cnt == 0) begin
        start = 1'b1; hi_sel = ~hi; op_segs = CNT_W'(nc == 0 ? 1 : 0);
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    chk(poke ? "R6 latency" : "R5 latency", 128'(cnt), 128'(nc + 1));
    chk("R5 busy low at done", {127'd0, busy}, 128'd0);
    for (int k = 0; k < NSEG; k++)
      chk((k < nc) ? tag : "R3 tail", dst[k*128 +: 128], nxt[k]);
    @(negedge clk);
    chk("R5 done pulse", {127'd0, done}, 128'd0);
    for (int k = 0; k < NSEG; k++) exp_seg[k] = nxt[k];
    alias_en = 1'b0;
  endtask

  task automatic fill_rand();
    for (int e = 0; e < NEL; e++) begin
      a_el[e] = {$urandom, $urandom};
      b_el[e] = {$urandom, $urandom};
    end
  endtask

  initial begin
    for (int e = 0; e < NEL; e++) begin a_el[e] = '0; b_el[e] = '0; end
    for (int k = 0; k < NSEG; k++) exp_seg[k] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 busy", {127'd0, busy}, 128'd0);
    chk("R8 done", {127'd0, done}, 128'd0);
    for (int k = 0; k < NSEG; k++) chk("R8 dst", dst[k*128 +: 128], 128'd0);

    // R1 walking single bits, distinct per element
    for (int x = 0; x < 64; x++) begin
      for (int e = 0; e < NEL; e++) begin
        a_el[e] = 64'd1 << ((x + e * 5) % 64);
        b_el[e] = 64'd1 << ((x * 3 + e * 11) % 64);
      end
      run_op(NSEG, x[0], 1'b0, 1'b0, x[0] ? "R2 walk" : "R1 walk");
    end

    // R2 / R3 size sweep incl. clamp (5..7) and zero
    for (int s = 7; s >= 0; s--) begin
      for (int h = 0; h < 2; h++) begin
        fill_rand();
        run_op(s, h[0], 1'b0, 1'b0, h[0] ? "R2 odd" : "R1 even");
      end
    end

    // R4 XOR-only results
    for (int e = 0; e < NEL; e++) begin a_el[e] = '1; b_el[e] = '1; end
    run_op(NSEG, 1'b0, 1'b0, 1'b0, "R4 ones");
    chk("R4 ones square", dst[127:0], {64'h5555555555555555, 64'h5555555555555555});
    fill_rand();
    for (int e = 0; e < NEL; e++) a_el[e] = 64'd1;
    run_op(NSEG, 1'b1, 1'b0, 1'b0, "R4 unit");
    chk("R4 unit operand", dst[255:128], {64'd0, b_el[3]});
    fill_rand();
    for (int e = 0; e < NEL; e++) begin a_el[e] = 64'h8000000000000000; b_el[e] = '1; end
    run_op(NSEG, 1'b0, 1'b0, 1'b0, "R4 top");
    chk("R4 bit127 zero", {127'd0, dst[127]}, 128'd0);

    // R6 start/config ignored while busy
    for (int s = 0; s <= NSEG; s++) begin
      fill_rand();
      run_op(s, s[0], 1'b0, 1'b1, "R6 poke");
    end

    // R7 destination aliased onto first source
    fill_rand();
    run_op(NSEG, 1'b0, 1'b0, 1'b0, "R7 seed");
    for (int h = 0; h < 2; h++) begin
      fill_rand();
      run_op(NSEG, h[0], 1'b1, 1'b0, "R7 alias");
    end
    fill_rand();
    run_op(2, 1'b1, 1'b1, 1'b0, "R7 alias short");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule